// File: doc/BRIEF.md
# Synchronous Rectifier Gate Controller

This block decides, cycle by cycle, when the gate of a secondary-side synchronous rectifier switch may conduct. Its inputs are three comparator flags on the switch's drain-source voltage, each already sampled:
- A turn-on flag: the voltage is below a negative threshold, meaning the body diode is conducting.
- A turn-off flag: the voltage is above a near-zero threshold.
- A reset flag: the voltage is above a positive threshold, meaning the secondary has stopped conducting.

It also takes a supply-good flag, an enable level and a minimum-on-time count given in clock cycles. It drives a gate-enable level and a 3-bit mode code.

After lockout or sleep, gating starts only at a clean cycle boundary. A minimum-on-time window hides turn-off ringing. A fixed blanking window after turn-off hides false turn-on triggers. When the secondary conducts for less than the minimum on time, the controller stops gating and keeps measuring each cycle until conduction is long enough again.

All control and status pins are plain levels with no handshake. The block has no streamed data path, so nothing here uses valid/ready or back-pressure.

Top module: `sr_gate_ctrl`

## Requirements
- R1: When supply-good is low, the block goes to lockout (mode 0) from any state, with the gate off. This has the highest priority.
- R2: When supply-good is high and enable is low, the block goes to sleep (mode 1) with the gate off.
- R3: Leaving lockout or sleep always leads to wait-sync (mode 2). In wait-sync the turn-on flag is ignored and the gate stays off. The first reset flag moves the block to armed (mode 3).
- R4: In armed, a turn-on flag moves the block to on-MOT (mode 4) and raises the gate.
- R5: On-MOT holds the gate on for exactly the programmed minimum-on-time count of cycles and ignores the turn-off flag. After that the block moves to on (mode 5).
- R6: In on, a turn-off flag drops the gate and starts blanking (mode 6).
- R7: Blanking ignores the turn-on flag. It returns to armed after the BLANK_CYC parameter number of cycles, or earlier as soon as the reset flag is seen.
- R8: A reset flag seen during on-MOT means conduction ended before the minimum on time. The gate drops at once and the block enters protect (mode 7).
- R9: In protect the gate stays off. Each conduction interval, from turn-on flag to turn-off flag, is timed. An interval shorter than the minimum on time keeps the block in protect.
- R10: A conduction interval in protect at least as long as the minimum on time moves the block to blanking (mode 6). Normal gating then resumes on the next cycle.
- R11: The minimum-on-time input is captured while in lockout or sleep. A captured value of 0 acts as 1.
- R12: Every flag input passes through a two-flop synchronizer. The mode therefore changes on the third rising edge after an input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above lockout level |
| enable | input | 1 | High for operation, low for sleep |
| vds_neg | input | 1 | Drain-source below turn-on threshold |
| vds_zero | input | 1 | Drain-source above turn-off threshold |
| vds_pos | input | 1 | Drain-source above reset threshold |
| mot_cycles | input | CNT_W | Minimum on time in clock cycles |
| gate_en | output | 1 | Gate drive request |
| mode | output | 3 | Current mode code (0 to 7, as in the requirements) |

## Verification
The bench drives turn-off ringing inside the minimum-on-time window. A controller that listens too early would drop the gate and never reach mode 5. It retriggers the turn-on flag during blanking, and also ends blanking early through the reset flag. A design that mishandles either would re-enter on-MOT or linger in blanking.

It raises the turn-on flag while the block is still waiting for synchronization. A design without the sync gate would start conducting mid-cycle. It feeds protect both a short and a long conduction interval, to catch a design that exits protect too eagerly or never exits. It also changes the minimum-on-time value during sleep, to show the new count is the one applied.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  typedef enum logic [2:0] {
    M_LOCKOUT = 3'd0,
    M_SLEEP   = 3'd1,
    M_WSYNC   = 3'd2,
    M_ARMED   = 3'd3,
    M_ONMOT   = 3'd4,
    M_ON      = 3'd5,
    M_BLANK   = 3'd6,
    M_PROTECT = 3'd7
  } sr_mode_e;
endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[i] <= 1'b0;
        s2[i] <= 1'b0;
      end else begin
        s1[i] <= d[i];
        s2[i] <= s1[i];
      end
    end
  end

  assign q = s2;
endmodule

// File: rtl/sr_timer.sv
module sr_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R5: the window counts down one step per cycle when not reloaded
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
  import sr_gate_pkg::*;
#(
  parameter int TW        = 12,
  parameter int BLANK_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_sup,
  input  logic          s_en,
  input  logic          s_neg,
  input  logic          s_zero,
  input  logic          s_pos,
  input  logic [TW-1:0] mot_q,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output sr_mode_e      state
);
  localparam logic [TW-1:0] BLANK_LOAD = TW'(BLANK_CYC - 1);

  sr_mode_e nxt;
  logic     meas, meas_nxt;
  logic     ld_mot, ld_blank;

  always_comb begin
    nxt      = state;
    meas_nxt = meas;
    ld_mot   = 1'b0;
    ld_blank = 1'b0;
    if (!s_sup) begin
      nxt      = M_LOCKOUT;
      meas_nxt = 1'b0;
    end else if (!s_en) begin
      nxt      = M_SLEEP;
      meas_nxt = 1'b0;
    end else begin
      unique case (state)
        M_LOCKOUT, M_SLEEP: nxt = M_WSYNC;
        M_WSYNC: if (s_pos) nxt = M_ARMED;
        M_ARMED: if (s_neg) begin
          nxt    = M_ONMOT;
          ld_mot = 1'b1;
        end
        M_ONMOT: begin
          if (s_pos) begin
            nxt      = M_PROTECT;
            meas_nxt = 1'b0;
          end else if (tmr_done) begin
            nxt = M_ON;
          end
        end
        M_ON: if (s_zero) begin
          nxt      = M_BLANK;
          ld_blank = 1'b1;
        end
        M_BLANK: if (s_pos || tmr_done) nxt = M_ARMED;
        M_PROTECT: begin
          if (!meas) begin
            if (s_neg) begin
              meas_nxt = 1'b1;
              ld_mot   = 1'b1;
            end
          end else if (s_zero) begin
            meas_nxt = 1'b0;
            if (tmr_done) begin
              nxt      = M_BLANK;
              ld_blank = 1'b1;
            end
          end
        end
        default: nxt = M_LOCKOUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= M_LOCKOUT;
      meas  <= 1'b0;
    end else begin
      state <= nxt;
      meas  <= meas_nxt;
    end
  end

  assign tmr_load = ld_mot | ld_blank;
  assign tmr_val  = ld_blank ? BLANK_LOAD : (mot_q - 1'b1);

  a_r1_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    !s_sup |=> state == M_LOCKOUT);
  a_r2_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (s_sup && !s_en) |=> state == M_SLEEP);
  a_r3_wait_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_WSYNC && s_sup && s_en && !s_pos) |=> state == M_WSYNC);
  a_r5_mot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_ONMOT && s_sup && s_en && !s_pos && !tmr_done) |=> state == M_ONMOT);
  a_r7_blank_no_on: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_BLANK) |=> state != M_ONMOT);
  a_r9_protect_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_PROTECT && s_sup && s_en && !s_zero) |=> state == M_PROTECT);
endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl
  import sr_gate_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int BLANK_CYC = 16,
  parameter int MOT_RST   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             enable,
  input  logic             vds_neg,
  input  logic             vds_zero,
  input  logic             vds_pos,
  input  logic [CNT_W-1:0] mot_cycles,
  output logic             gate_en,
  output logic [2:0]       mode
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] s_q;
  logic [CNT_W-1:0] mot_q, tmr_val;
  logic             tmr_load, tmr_done;
  sr_mode_e         state;

  sr_sync #(.W(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({supply_ok, enable, vds_neg, vds_zero, vds_pos}),
    .q     (s_q)
  );

  // minimum on time is only taken in while the gate cannot be active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mot_q <= CNT_W'(MOT_RST);
    else if (state == M_LOCKOUT || state == M_SLEEP)
      mot_q <= (mot_cycles == '0) ? CNT_W'(1) : mot_cycles;
  end

  sr_timer #(.TW(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sr_fsm #(.TW(CNT_W), .BLANK_CYC(BLANK_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_sup    (s_q[4]),
    .s_en     (s_q[3]),
    .s_neg    (s_q[2]),
    .s_zero   (s_q[1]),
    .s_pos    (s_q[0]),
    .mot_q    (mot_q),
    .tmr_done (tmr_done),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .state    (state)
  );

  assign gate_en = (state == M_ONMOT) || (state == M_ON);
  assign mode    = state;

  // R11: captured count never zero
  a_r11_mot_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    mot_q != '0);
endmodule

// File: tb/tb_sr_gate_ctrl.sv
module tb_sr_gate_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        supply_ok = 1'b0, enable = 1'b0;
  logic        vds_neg = 1'b0, vds_zero = 1'b0, vds_pos = 1'b0;
  logic [11:0] mot_cycles = 12'd20;
  logic        gate_en;
  logic [2:0]  mode;
  int total = 0, bad = 0;
  bit timed_out = 1'b0;

  always #5 clk = ~clk;

  sr_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
    .vds_neg(vds_neg), .vds_zero(vds_zero), .vds_pos(vds_pos),
    .mot_cycles(mot_cycles), .gate_en(gate_en), .mode(mode)
  );

  // {sup,en,neg,zero,pos, hold[7:0], mode[2:0], gate, req[3:0]}
  localparam int NV = 24;
  localparam logic [20:0] VEC [0:NV-1] = '{
    {5'b00000, 8'd4,  3'd0, 1'b0, 4'd1},   // R1 lockout
    {5'b10000, 8'd4,  3'd1, 1'b0, 4'd2},   // R2 sleep
    {5'b11100, 8'd6,  3'd2, 1'b0, 4'd3},   // R3 turn-on ignored before sync
    {5'b11001, 8'd4,  3'd3, 1'b0, 4'd3},   // R3 reset flag arms
    {5'b11000, 8'd4,  3'd3, 1'b0, 4'd4},
    {5'b11100, 8'd4,  3'd4, 1'b1, 4'd4},   // R4 turn-on
    {5'b11010, 8'd4,  3'd4, 1'b1, 4'd5},   // R5 ringing ignored
    {5'b11000, 8'd20, 3'd5, 1'b1, 4'd5},   // R5 window over
    {5'b11010, 8'd4,  3'd6, 1'b0, 4'd6},   // R6 turn-off
    {5'b11100, 8'd4,  3'd6, 1'b0, 4'd7},   // R7 retrigger blanked
    {5'b11000, 8'd12, 3'd3, 1'b0, 4'd7},   // R7 blank timeout
    {5'b11100, 8'd4,  3'd4, 1'b1, 4'd4},
    {5'b11000, 8'd30, 3'd5, 1'b1, 4'd5},
    {5'b11010, 8'd4,  3'd6, 1'b0, 4'd6},
    {5'b11001, 8'd4,  3'd3, 1'b0, 4'd7},   // R7 early end
    {5'b11100, 8'd4,  3'd4, 1'b1, 4'd4},
    {5'b11001, 8'd4,  3'd7, 1'b0, 4'd8},   // R8 short conduction
    {5'b11100, 8'd10, 3'd7, 1'b0, 4'd9},   // R9 measuring, gate off
    {5'b11010, 8'd4,  3'd7, 1'b0, 4'd9},   // R9 short stays protect
    {5'b11100, 8'd30, 3'd7, 1'b0, 4'd9},
    {5'b11010, 8'd4,  3'd6, 1'b0, 4'd10},  // R10 long -> blanking
    {5'b11000, 8'd20, 3'd3, 1'b0, 4'd10},
    {5'b11100, 8'd4,  3'd4, 1'b1, 4'd10},  // R10 gating resumed
    {5'b01100, 8'd4,  3'd0, 1'b0, 4'd1}    // R1 from on-MOT
  };

  task automatic check(input logic [2:0] em, input logic eg, input int req);
    total++;
    if (mode !== em || gate_en !== eg) begin
      bad++;
      $display("FAIL R%0d: mode=%0d gate=%0b expected mode=%0d gate=%0b",
               req, mode, gate_en, em, eg);
    end
  endtask

  task automatic drive(input logic [4:0] f);
    {supply_ok, enable, vds_neg, vds_zero, vds_pos} = f;
  endtask

  task automatic step(input logic [4:0] f, input int hold,
                      input logic [2:0] em, input logic eg, input int req);
    drive(f);
    repeat (hold) @(posedge clk);
    @(negedge clk);
    check(em, eg, req);
  endtask

  initial begin
    #2_000_000;
    timed_out = 1'b1;
    total++; bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(3'd0, 1'b0, 1);               // R1 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      step(VEC[i][20:16], int'(VEC[i][15:8]), VEC[i][7:5], VEC[i][4], int'(VEC[i][3:0]));

    // R12: two-flop latency, mode changes on third edge
    step(5'b11000, 4, 3'd2, 1'b0, 12);
    drive(5'b11001);
    repeat (2) @(posedge clk); @(negedge clk);
    check(3'd2, 1'b0, 12);              // R12 not yet
    @(posedge clk); @(negedge clk);
    check(3'd3, 1'b0, 12);              // R12 now armed

    // R2: enable low during on drops gate
    step(5'b11100, 4, 3'd4, 1'b1, 2);
    step(5'b10000, 4, 3'd1, 1'b0, 2);

    // R11: new count 40 captured in sleep
    mot_cycles = 12'd40;
    step(5'b10000, 3, 3'd1, 1'b0, 11);
    step(5'b11001, 6, 3'd3, 1'b0, 11);
    step(5'b11100, 30, 3'd4, 1'b1, 11); // R11 still inside 40-cycle window
    step(5'b11000, 15, 3'd5, 1'b1, 11);

    // R11: zero count acts as one
    mot_cycles = 12'd0;
    step(5'b10000, 4, 3'd1, 1'b0, 11);
    step(5'b11001, 6, 3'd3, 1'b0, 11);
    step(5'b11100, 4, 3'd5, 1'b1, 11);

    if (!timed_out) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule